// File: doc/BRIEF.md
# Strap Capture and Reset Sequencer

This block samples a set of configuration straps from a shared parallel bus once, when the active-high hardware reset pin is released. The straps are the levels that board resistors place on pins the chip will later drive. After capture the straps are frozen. They are decoded into the following chip-wide settings:

- whether the processor is internal or external,
- whether boot code comes from on-chip or off-chip ROM,
- what the shared bus carries once it is driven,
- the two low bits of the I2C target address.

The block also produces the internal core reset. After the pin is released, the core reset is held for a stretch period. One strap chooses between a long stretch (about 10 ms at the crystal rate) and a short stretch of 32 clocks. When the stretch ends, the core reset drops and the shared bus is turned around to output.

A low-voltage guard can be enabled by a strap. While the core is running, the external low-voltage flag must stay high for an unbroken window before it triggers a reset. The window length is chosen by two strap bits. When the guard triggers, the core reset is re-asserted and the same stretch runs again, without sampling the straps a second time.

Top module: `strap_rst_seq`

## Requirements
- R1: While `rst_pin` is high, `core_rst` is 1 and `bus_drive_en` is 0. The captured straps read as zero, so `ext_cpu`, `ext_boot` and `host_bus_mode` are 0 and `i2c_addr` is 7'h34.
- R2: The straps are taken from `strap_bus` on the first rising clock edge at which `rst_pin` is low. Later changes on `strap_bus` have no effect on any output until the next reset.
- R3: `ext_cpu` equals strap bit 0 (1 = external processor). `ext_boot` equals strap bit 6 (1 = off-chip ROM). `host_bus_mode` equals strap bit 10 (1 = bus carries the parallel host port, 0 = video output).
- R4: Strap bits [4:3] select the 8-bit I2C address 68h, 6Ah, 6Ch or 6Eh for codes 0 to 3. `i2c_addr` is the 7-bit form, which is 7'h34 plus the code.
- R5: Strap bit 1 selects the stretch length L. A value of 0 gives NORMAL_CYCLES (default 120000) and 1 gives FAST_CYCLES (default 32). `core_rst` falls after the L-th rising edge that follows the capture edge.
- R6: `bus_drive_en` is 1 exactly when `core_rst` is 0.
- R7: When strap bit 7 is 0, `lv_det` has no effect.
- R8: When strap bit 7 is 1 and the core is running, `core_rst` rises after D consecutive rising edges that sample `lv_det` high. D is LV_BASE shifted left by strap bits [9:8], so the defaults are 64, 128, 256 and 512.
- R9: A single edge that samples `lv_det` low before D is reached restarts the count from zero.
- R10: After a low-voltage reset, the stretch of length L runs again. The straps keep their captured values.
- R11: Raising `rst_pin` at any point returns the block to the R1 state. The next release captures the straps again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_pin | input | 1 | Hardware reset, active high, asynchronous assert |
| strap_bus | input | STRAP_W | Shared bus levels sampled as straps |
| lv_det | input | 1 | Low-voltage detect flag |
| core_rst | output | 1 | Internal reset, active high |
| bus_drive_en | output | 1 | Shared bus output enable |
| ext_cpu | output | 1 | External processor selected |
| ext_boot | output | 1 | Off-chip boot ROM selected |
| host_bus_mode | output | 1 | Bus carries host port instead of video |
| i2c_addr | output | 7 | 7-bit I2C target address |

## Verification
A wrong capture register shows up as bad decode outputs in the first cycle after release. It also shows as a wrong stretch length or a wrong low-voltage window one stretch later. A counter that is off by one moves the fall of `core_rst` or `bus_drive_en` by one cycle, and the per-clock comparison against the bench model reports it in that cycle. A guard that fails to restart on a short drop of `lv_det` fires a reset that the model does not expect, and this appears at `core_rst` within the window length.

// File: rtl/strap_pkg.sv
package strap_pkg;

   // Bit positions on the strap bus; neighbours decode these positions.
   localparam int POS_CPU     = 0;
   localparam int POS_FAST    = 1;
   localparam int POS_ADDR_LO = 3;
   localparam int POS_BOOT    = 6;
   localparam int POS_LV_EN   = 7;
   localparam int POS_LV_LO   = 8;
   localparam int POS_BUSMODE = 10;
   localparam int STRAP_MIN_W = 11;

   typedef struct packed {
      logic       host_bus;
      logic [1:0] lv_sel;
      logic       lv_en;
      logic       ext_boot;
      logic [1:0] addr_sel;
      logic       fast_rst;
      logic       ext_cpu;
   } strap_cfg_t;

   typedef enum logic [1:0] {
      SEQ_WAIT    = 2'd0,
      SEQ_STRETCH = 2'd1,
      SEQ_RUN     = 2'd2
   } seq_state_t;

   function automatic strap_cfg_t unpack_straps(input logic [STRAP_MIN_W-1:0] s);
      strap_cfg_t c;
      c.ext_cpu  = s[POS_CPU];
      c.fast_rst = s[POS_FAST];
      c.addr_sel = s[POS_ADDR_LO +: 2];
      c.ext_boot = s[POS_BOOT];
      c.lv_en    = s[POS_LV_EN];
      c.lv_sel   = s[POS_LV_LO +: 2];
      c.host_bus = s[POS_BUSMODE];
      return c;
   endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_pin,
   input  logic [W-1:0] strap_bus,
   output logic [W-1:0] strap_q,
   output logic         cap_pulse
);

   logic armed_q;

   // Armed while the pin is high; the first edge with the pin low takes the bus.
   assign cap_pulse = armed_q && !rst_pin;

   always_ff @(posedge clk or posedge rst_pin) begin
      if (rst_pin) begin
         armed_q <= 1'b1;
         strap_q <= '0;
      end else if (cap_pulse) begin
         armed_q <= 1'b0;
         strap_q <= strap_bus;
      end
   end

endmodule

// File: rtl/rst_stretch.sv
module rst_stretch
   import strap_pkg::*;
#(
   parameter int NORMAL_CYCLES = 120000,
   parameter int FAST_CYCLES   = 32
) (
   input  logic clk,
   input  logic rst_pin,
   input  logic start,
   input  logic fast,
   output logic run
);

   localparam int MAX_LEN = (NORMAL_CYCLES > FAST_CYCLES) ? NORMAL_CYCLES : FAST_CYCLES;
   localparam int SCW     = $clog2(MAX_LEN);
   localparam logic [SCW-1:0] NORM_LAST = SCW'(NORMAL_CYCLES - 1);
   localparam logic [SCW-1:0] FAST_LAST = SCW'(FAST_CYCLES - 1);

   seq_state_t     state_q;
   logic [SCW-1:0] cnt_q;
   logic [SCW-1:0] last;

   assign last = fast ? FAST_LAST : NORM_LAST;
   assign run  = (state_q == SEQ_RUN);

   always_ff @(posedge clk or posedge rst_pin) begin
      if (rst_pin) begin
         state_q <= SEQ_WAIT;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            SEQ_WAIT: begin
               if (start) begin
                  state_q <= SEQ_STRETCH;
                  cnt_q   <= '0;
               end
            end
            SEQ_STRETCH: begin
               if (cnt_q == last) begin
                  state_q <= SEQ_RUN;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SEQ_RUN: begin
               if (start) begin
                  state_q <= SEQ_STRETCH;
                  cnt_q   <= '0;
               end
            end
            default: begin
               state_q <= SEQ_WAIT;
               cnt_q   <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/lv_qualify.sv
module lv_qualify #(
   parameter int LV_BASE = 64
) (
   input  logic       clk,
   input  logic       rst_pin,
   input  logic       active,
   input  logic       det,
   input  logic [1:0] sel,
   output logic       fire
);

   localparam int LCW = $clog2(LV_BASE * 8);

   logic [LCW-1:0] cnt_q;
   logic [LCW-1:0] dly_last [4];
   logic [LCW-1:0] last;

   for (genvar i = 0; i < 4; i++) begin : g_dly
      assign dly_last[i] = LCW'(LV_BASE * (1 << i) - 1);
   end

   assign last = dly_last[sel];
   assign fire = active && det && (cnt_q == last);

   // Any low sample, or leaving run, restarts the window.
   always_ff @(posedge clk or posedge rst_pin) begin
      if (rst_pin) begin
         cnt_q <= '0;
      end else if (!active || !det || fire) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/strap_rst_seq.sv
module strap_rst_seq
   import strap_pkg::*;
#(
   parameter int         STRAP_W       = 11,
   parameter int         NORMAL_CYCLES = 120000,
   parameter int         FAST_CYCLES   = 32,
   parameter int         LV_BASE       = 64,
   parameter bit         LV_PRESENT    = 1'b1,
   parameter logic [6:0] I2C_BASE      = 7'h34
) (
   input  logic               clk,
   input  logic               rst_pin,
   input  logic [STRAP_W-1:0] strap_bus,
   input  logic               lv_det,
   output logic               core_rst,
   output logic               bus_drive_en,
   output logic               ext_cpu,
   output logic               ext_boot,
   output logic               host_bus_mode,
   output logic [6:0]         i2c_addr
);

   if (STRAP_W < STRAP_MIN_W) begin : g_bad_width
      $error("strap_rst_seq: STRAP_W below %0d", STRAP_MIN_W);
   end
   if (NORMAL_CYCLES < 2 || FAST_CYCLES < 2) begin : g_bad_len
      $error("strap_rst_seq: stretch lengths must be at least 2");
   end
   if (LV_BASE < 1) begin : g_bad_lv
      $error("strap_rst_seq: LV_BASE must be positive");
   end

   logic [STRAP_W-1:0] strap_q;
   logic               cap_pulse;
   logic               lv_fire;
   logic               run;
   strap_cfg_t         cfg;

   strap_capture #(.W(STRAP_W)) u_cap (
      .clk       (clk),
      .rst_pin   (rst_pin),
      .strap_bus (strap_bus),
      .strap_q   (strap_q),
      .cap_pulse (cap_pulse)
   );

   assign cfg = unpack_straps(strap_q[STRAP_MIN_W-1:0]);

   rst_stretch #(
      .NORMAL_CYCLES (NORMAL_CYCLES),
      .FAST_CYCLES   (FAST_CYCLES)
   ) u_stretch (
      .clk     (clk),
      .rst_pin (rst_pin),
      .start   (cap_pulse || lv_fire),
      .fast    (cfg.fast_rst),
      .run     (run)
   );

   if (LV_PRESENT) begin : g_lv
      lv_qualify #(.LV_BASE(LV_BASE)) u_lv (
         .clk     (clk),
         .rst_pin (rst_pin),
         .active  (run && cfg.lv_en),
         .det     (lv_det),
         .sel     (cfg.lv_sel),
         .fire    (lv_fire)
      );
   end else begin : g_no_lv
      assign lv_fire = 1'b0;
   end

   assign core_rst      = !run;
   assign bus_drive_en  = run;
   assign ext_cpu       = cfg.ext_cpu;
   assign ext_boot      = cfg.ext_boot;
   assign host_bus_mode = cfg.host_bus;
   assign i2c_addr      = I2C_BASE + 7'(cfg.addr_sel);

endmodule

// File: rtl/strap_rst_seq_chk.sv
module strap_rst_seq_chk #(
   parameter int STRAP_W       = 11,
   parameter int NORMAL_CYCLES = 120000,
   parameter int FAST_CYCLES   = 32,
   parameter int LV_BASE       = 64
) (
   input logic               clk,
   input logic               rst_pin,
   input logic               lv_det,
   input logic               core_rst,
   input logic               bus_drive_en,
   input logic [9:0]         cfg_out,
   input logic [STRAP_W-1:0] strap_q
);

   int held_cnt;
   int lv_streak;

   // Edges with core reset high since the last running cycle.
   always_ff @(posedge clk or posedge rst_pin) begin
      if (rst_pin) begin
         held_cnt  <= 0;
         lv_streak <= 0;
      end else begin
         held_cnt  <= core_rst ? held_cnt + 1 : 1;
         lv_streak <= (!core_rst && strap_q[7] && lv_det) ? lv_streak + 1 : 0;
      end
   end

   always @(posedge clk) begin
      if (rst_pin) begin
         a_r1_reset_hold: assert (core_rst && !bus_drive_en)
            else $error("R1: reset pin high but core released");
      end
   end

   a_r2_straps_frozen: assert property (@(posedge clk) disable iff (rst_pin)
      !core_rst |=> ($stable(strap_q) && $stable(cfg_out)))
      else $error("R2: straps changed after release");

   a_r5_stretch_len: assert property (@(posedge clk) disable iff (rst_pin)
      $fell(core_rst) |-> (held_cnt == (strap_q[1] ? FAST_CYCLES : NORMAL_CYCLES) + 1))
      else $error("R5: stretch length wrong");

   a_r7_lv_off: assert property (@(posedge clk) disable iff (rst_pin)
      !strap_q[7] |-> !$rose(core_rst))
      else $error("R7: low-voltage reset while disabled");

   a_r8_full_window: assert property (@(posedge clk) disable iff (rst_pin)
      $rose(core_rst) |-> (lv_streak == (LV_BASE << strap_q[9:8])))
      else $error("R8: low-voltage reset without full window");

endmodule

bind strap_rst_seq strap_rst_seq_chk #(
   .STRAP_W       (STRAP_W),
   .NORMAL_CYCLES (NORMAL_CYCLES),
   .FAST_CYCLES   (FAST_CYCLES),
   .LV_BASE       (LV_BASE)
) u_chk (
   .clk          (clk),
   .rst_pin      (rst_pin),
   .lv_det       (lv_det),
   .core_rst     (core_rst),
   .bus_drive_en (bus_drive_en),
   .cfg_out      ({ext_cpu, ext_boot, host_bus_mode, i2c_addr}),
   .strap_q      (strap_q)
);

// File: tb/strap_rst_seq_tb.sv
module strap_rst_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int SW   = 11;
   localparam int NORM = 200;
   localparam int FAST = 32;
   localparam int LVB  = 64;

   logic          clk = 1'b0;
   logic          rst_pin;
   logic [SW-1:0] bus;
   logic          lv_det;
   logic          core_rst, bus_drive_en, ext_cpu, ext_boot, host_bus_mode;
   logic [6:0]    i2c_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   strap_rst_seq #(
      .STRAP_W(SW), .NORMAL_CYCLES(NORM), .FAST_CYCLES(FAST), .LV_BASE(LVB)
   ) u_dut (
      .clk(clk), .rst_pin(rst_pin), .strap_bus(bus), .lv_det(lv_det),
      .core_rst(core_rst), .bus_drive_en(bus_drive_en), .ext_cpu(ext_cpu),
      .ext_boot(ext_boot), .host_bus_mode(host_bus_mode), .i2c_addr(i2c_addr)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [SW-1:0] mk(input bit cpu, input bit fast, input int addr,
                                         input bit boot, input bit lven, input int lvsel,
                                         input bit host);
      logic [SW-1:0] s = '0;
      s[0] = cpu; s[1] = fast; s[4:3] = 2'(addr); s[6] = boot;
      s[7] = lven; s[9:8] = 2'(lvsel); s[10] = host;
      return s;
   endfunction

   function automatic logic [6:0] addr7(input int sel);
      logic [7:0] a8 = 8'h68 + 8'(2 * sel);
      return a8[7:1];
   endfunction

   // Behavioural reference: phase 0 waiting, 1 stretching, 2 running.
   int            m_phase = 0;
   int            m_sc = 0;
   int            m_lc = 0;
   logic [SW-1:0] m_st = '0;

   always @(posedge clk) begin
      if (rst_pin === 1'b1) begin
         m_phase = 0; m_st = '0; m_sc = 0; m_lc = 0;
      end else if (m_phase == 0) begin
         m_st = bus; m_phase = 1; m_sc = 0;
      end else if (m_phase == 1) begin
         m_sc++;
         if (m_sc == (m_st[1] ? FAST : NORM)) begin m_phase = 2; m_lc = 0; end
      end else begin
         if (m_st[7] && lv_det) begin
            m_lc++;
            if (m_lc == (LVB << m_st[9:8])) begin m_phase = 1; m_sc = 0; m_lc = 0; end
         end else begin
            m_lc = 0;
         end
      end
      #1;
      if (!done) begin
         chk("R5 R8 R10 core_rst", core_rst, m_phase != 2);
         chk("R6 bus_drive_en", bus_drive_en, m_phase == 2);
         chk("R3 ext_cpu", ext_cpu, m_st[0]);
         chk("R3 ext_boot", ext_boot, m_st[6]);
         chk("R3 host_bus_mode", host_bus_mode, m_st[10]);
         chk("R4 i2c_addr", i2c_addr, addr7(int'(m_st[4:3])));
      end
   end

   // Release reset with the given straps, scramble the bus after capture,
   // and count edges until the core reset drops.
   task automatic release_and_time(input logic [SW-1:0] s, input int len, input string tag);
      int n;
      @(negedge clk); bus = s; rst_pin = 1'b0;
      @(posedge clk); n = 1;
      @(negedge clk); bus = ~s;
      while (core_rst === 1'b1 && n < NORM + 10) begin
         @(posedge clk); #2; n++;
      end
      chk(tag, n, len + 1);
   endtask

   task automatic hold_lv(input int cycles);
      @(negedge clk); lv_det = 1'b1;
      repeat (cycles - 1) @(negedge clk);
      @(negedge clk); lv_det = 1'b0;
   endtask

   task automatic time_restretch(input int len, input string tag);
      int n = 0;
      while (core_rst === 1'b1 && n < NORM + 10) begin
         @(posedge clk); #2; n++;
      end
      chk(tag, n, len);
   endtask

   initial begin
      logic [SW-1:0] s;
      rst_pin = 1'b0; bus = '0; lv_det = 1'b0;
      #2 rst_pin = 1'b1;
      bus = '1;
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1 core_rst", core_rst, 1'b1);
      chk("R1 bus_drive_en", bus_drive_en, 1'b0);
      chk("R1 ext_cpu", ext_cpu, 1'b0);
      chk("R1 i2c_addr", i2c_addr, 7'h34);

      // Normal stretch, all straps low, bus scrambled after capture (R2, R5)
      s = mk(0, 0, 0, 0, 0, 0, 0);
      release_and_time(s, NORM, "R5 normal stretch");
      chk("R2 ext_cpu ignores later bus", ext_cpu, 1'b0);
      chk("R2 host_bus_mode ignores later bus", host_bus_mode, 1'b0);
      chk("R6 drive after release", bus_drive_en, 1'b1);

      // R11: reassert reset and capture a new word, fast stretch
      @(negedge clk); rst_pin = 1'b1;
      @(negedge clk);
      chk("R11 core_rst back on", core_rst, 1'b1);
      chk("R11 drive off", bus_drive_en, 1'b0);
      s = mk(1, 1, 3, 1, 1, 0, 1);
      release_and_time(s, FAST, "R5 fast stretch");
      chk("R3 ext_cpu", ext_cpu, 1'b1);
      chk("R3 ext_boot", ext_boot, 1'b1);
      chk("R3 host_bus_mode", host_bus_mode, 1'b1);
      chk("R4 addr code 3", i2c_addr, addr7(3));

      // R9: windows one short of 64 with a single low edge in between
      hold_lv(LVB - 1);
      hold_lv(LVB - 1);
      #1 chk("R9 no reset on broken window", core_rst, 1'b0);
      // R8: full window of 64 fires
      hold_lv(LVB);
      #1 chk("R8 reset after full window", core_rst, 1'b1);
      time_restretch(FAST, "R10 restretch length");
      chk("R10 straps kept ext_cpu", ext_cpu, 1'b1);
      chk("R10 straps kept addr", i2c_addr, addr7(3));

      // R7: guard disabled, long detect has no effect
      @(negedge clk); rst_pin = 1'b1;
      s = mk(0, 1, 1, 0, 0, 3, 0);
      release_and_time(s, FAST, "R5 fast stretch again");
      chk("R4 addr code 1", i2c_addr, addr7(1));
      hold_lv(600);
      #1 chk("R7 guard off ignores detect", core_rst, 1'b0);

      // R8 with the longest window (512), and R11 mid-stretch
      @(negedge clk); rst_pin = 1'b1;
      s = mk(0, 1, 2, 0, 1, 3, 0);
      release_and_time(s, FAST, "R5 fast stretch third");
      chk("R4 addr code 2", i2c_addr, addr7(2));
      hold_lv(511);
      #1 chk("R9 511 edges not enough", core_rst, 1'b0);
      hold_lv(512);
      #1 chk("R8 512 window fires", core_rst, 1'b1);
      repeat (5) @(negedge clk);
      rst_pin = 1'b1;
      @(negedge clk);
      chk("R11 reset mid-stretch", bus_drive_en, 1'b0);
      chk("R11 straps cleared", i2c_addr, 7'h34);
      s = mk(1, 0, 0, 0, 0, 0, 1);
      release_and_time(s, NORM, "R11 recapture normal stretch");
      chk("R11 new ext_cpu", ext_cpu, 1'b1);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule